// File: doc/BRIEF.md
# Wavetable Voice Bank Read Decoder

This block is the byte-wide read side of a 32-voice wavetable sound generator. A read request carries an 8-bit offset. Offsets in the lower seven eighths of the space address per-voice registers: the top three bits pick a register group and the low five bits pick the voice. The top eighth holds global registers: an interrupt status register, a voice-count register and a pass-through of an external converter byte.

The interrupt status register is the centre of the block. Reading it hands the interrupt handler the lowest-numbered enabled voice whose pending flag is set. During the strobe cycle the block pulses a clear for that voice's flag, which sits outside the block. On the same edge it latches the result into a sticky status byte. The interrupt line stays high while any other enabled voice is still pending. The block owns no voice state: frequencies, volumes, samples, pointers, control bytes and pending flags all come in on ports from the voice engine.

Top module: `snd_rd_decoder`

## Requirements
- R1: For offsets 0x00 to 0xBF, bits 7:5 select a group and bits 4:0 select voice v. Group 0 returns frequency bits 7:0 of v, group 1 frequency bits 15:8, group 2 volume, group 3 last sample byte, group 4 table pointer bits 15:8 (pointer page bits 7:0), and group 5 the control byte.
- R2: Group 6 (offsets 0xC0 to 0xDF) returns a packed byte: bit 7 is 0, bit 6 is pointer bit 16 (pointer page bit 8), bits 5:3 are the table-size code and bits 2:0 are the resolution code of voice v.
- R3: Read data and rdValid appear on the clock edge that follows a cycle with rdEn high. rdValid is low after a cycle without rdEn, and rdData then keeps its previous value.
- R4: A read at 0xE0 drives pendClear during the strobe cycle with exactly one bit set: the lowest index i with irqPend[i] high and i < enCount. If no enabled voice is pending, pendClear stays zero. pendClear is zero in every other cycle.
- R5: A read at 0xE0 returns (i<<1)|0x41 when voice i was chosen, and otherwise the stored status ORed with 0x41. When a voice is chosen, the stored status becomes 0x80|(i<<1). The stored status is 0 after reset.
- R6: On every clock edge, irqOut is set to whether any enabled voice is pending and is not being cleared in that cycle.
- R7: A read at 0xE1 returns (enCount-1)<<1.
- R8: A read at 0xE2 returns adcValue.
- R9: Reads at offsets 0xE3 to 0xFF return 0.
- R10: A pending flag set by the voice engine in the same cycle as an interrupt status read is not lost. A later read reports it.
- R11: After reset, rdData, rdValid and irqOut are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdEn | input | 1 | Read strobe |
| rdAddr | input | 8 | Read offset |
| oscFreq | input | 32x16 | Frequency word per voice |
| oscVolume | input | 32x8 | Volume per voice |
| oscSample | input | 32x8 | Last fetched sample byte per voice |
| oscPtrPage | input | 32x9 | Table pointer bits 16:8 per voice |
| oscControl | input | 32x8 | Control byte per voice |
| oscTblSize | input | 32x3 | Table-size code per voice |
| oscRes | input | 32x3 | Resolution code per voice |
| irqPend | input | 32 | Pending interrupt flags per voice |
| enCount | input | 6 | Number of enabled voices, 1 to 32 |
| adcValue | input | 8 | External converter byte |
| rdData | output | 8 | Registered read data |
| rdValid | output | 1 | Read data valid, one cycle after rdEn |
| irqOut | output | 1 | Interrupt request line |
| pendClear | output | 32 | One-hot clear of the reported voice's flag |

## Verification
Each cycle, the bench compares the design against a behavioural model that holds the pending flags and the sticky status. The corner cases are:
- Back-to-back status reads with several voices pending. A decoder that picks the wrong priority would report out of order. One that never clears would report the same voice twice.
- A pending voice above enCount. A design that ignores the enable count would report it or raise the line.
- An empty status read. A design that does not latch the sticky status would return the wrong byte.
- A flag re-set in the very cycle it is cleared. A design that clears it blindly would lose the event.
- A sweep of every per-voice offset. This catches swapped groups or a wrongly packed bank byte.

// File: rtl/snd_rd_pkg.sv
package snd_rd_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 8;
  localparam int GRP_W   = 3;
  localparam int IDX_W   = ADDR_W - GRP_W;
  localparam int NUM_OSC = 1 << IDX_W;
  localparam int CNT_W   = IDX_W + 1;
  localparam int FREQ_W  = 2 * DATA_W;
  localparam int PAGE_W  = DATA_W + 1;
  localparam int TBL_W   = 3;
  localparam int RES_W   = 3;

  localparam logic [ADDR_W-1:0] OFS_STATUS = 8'hE0;
  localparam logic [ADDR_W-1:0] OFS_COUNT  = 8'hE1;
  localparam logic [ADDR_W-1:0] OFS_ADC    = 8'hE2;
  localparam logic [DATA_W-1:0] STATUS_OR  = 8'h41;

  typedef enum logic [GRP_W-1:0] {
    GRP_FREQ_LO  = 3'd0,
    GRP_FREQ_HI  = 3'd1,
    GRP_VOLUME   = 3'd2,
    GRP_SAMPLE   = 3'd3,
    GRP_PTR_PAGE = 3'd4,
    GRP_CONTROL  = 3'd5,
    GRP_PACKED   = 3'd6,
    GRP_GLOBAL   = 3'd7
  } regGroup_e;

  typedef enum logic [1:0] {
    GLB_NONE,
    GLB_STATUS,
    GLB_COUNT,
    GLB_ADC
  } globalSel_e;

  typedef struct packed {
    logic       load;
    logic       oscRead;
    regGroup_e  group;
    globalSel_e glb;
    logic       popStatus;
  } rdStrobe_t;
endpackage

// File: rtl/snd_rd_prio.sv
module snd_rd_prio
  import snd_rd_pkg::*;
#(
  parameter int REQ_N = NUM_OSC,
  localparam int SEL_W = $clog2(REQ_N)
) (
  input  logic [REQ_N-1:0] req,
  output logic             found,
  output logic [SEL_W-1:0] winIdx,
  output logic [REQ_N-1:0] grant
);
  // Scan from the top down so the lowest requester is written last and wins.
  always_comb begin
    found  = 1'b0;
    winIdx = '0;
    grant  = '0;
    for (int i = REQ_N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found    = 1'b1;
        winIdx   = SEL_W'(i);
        grant    = '0;
        grant[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/snd_rd_ctrl.sv
module snd_rd_ctrl
  import snd_rd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output rdStrobe_t         strb,
  output logic [IDX_W-1:0]  oscSel,
  output logic              rdValid
);
  regGroup_e addrGroup;

  assign addrGroup = regGroup_e'(rdAddr[ADDR_W-1 -: GRP_W]);
  assign oscSel    = rdAddr[IDX_W-1:0];

  always_comb begin
    strb.load      = rdEn;
    strb.group     = addrGroup;
    strb.oscRead   = (addrGroup != GRP_GLOBAL);
    strb.popStatus = 1'b0;
    strb.glb       = GLB_NONE;
    if (addrGroup == GRP_GLOBAL) begin
      unique case (rdAddr)
        OFS_STATUS: begin
          strb.glb       = GLB_STATUS;
          strb.popStatus = rdEn;
        end
        OFS_COUNT: strb.glb = GLB_COUNT;
        OFS_ADC:   strb.glb = GLB_ADC;
        default:   strb.glb = GLB_NONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdValid <= 1'b0;
    else       rdValid <= rdEn;
  end

  AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid); // R3
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> !rdValid); // R3
endmodule

// File: rtl/snd_rd_dp.sv
module snd_rd_dp
  import snd_rd_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  rdStrobe_t                       strb,
  input  logic [IDX_W-1:0]                oscSel,
  input  logic [NUM_OSC-1:0][FREQ_W-1:0]  oscFreq,
  input  logic [NUM_OSC-1:0][DATA_W-1:0]  oscVolume,
  input  logic [NUM_OSC-1:0][DATA_W-1:0]  oscSample,
  input  logic [NUM_OSC-1:0][PAGE_W-1:0]  oscPtrPage,
  input  logic [NUM_OSC-1:0][DATA_W-1:0]  oscControl,
  input  logic [NUM_OSC-1:0][TBL_W-1:0]   oscTblSize,
  input  logic [NUM_OSC-1:0][RES_W-1:0]   oscRes,
  input  logic [NUM_OSC-1:0]              irqPend,
  input  logic [CNT_W-1:0]                enCount,
  input  logic [DATA_W-1:0]               adcValue,
  output logic [DATA_W-1:0]               rdData,
  output logic                            irqOut,
  output logic [NUM_OSC-1:0]              pendClear
);
  logic [NUM_OSC-1:0] enMask;
  logic [NUM_OSC-1:0] eligible;
  logic [NUM_OSC-1:0] grant;
  logic               found;
  logic [IDX_W-1:0]   winIdx;
  logic [DATA_W-1:0]  statusReg;
  logic [DATA_W-1:0]  oscByte;
  logic [DATA_W-1:0]  globalByte;
  logic [DATA_W-1:0]  nextData;
  logic [DATA_W-1:0]  winCode;

  for (genvar g = 0; g < NUM_OSC; g++) begin : g_enable
    assign enMask[g] = (CNT_W'(g) < enCount);
  end

  assign eligible = irqPend & enMask;

  snd_rd_prio #(.REQ_N(NUM_OSC)) u_prio (
    .req    (eligible),
    .found  (found),
    .winIdx (winIdx),
    .grant  (grant)
  );

  assign pendClear = strb.popStatus ? grant : '0;
  assign winCode   = {{(DATA_W-IDX_W-1){1'b0}}, winIdx, 1'b0};

  always_comb begin
    unique case (strb.group)
      GRP_FREQ_LO:  oscByte = oscFreq[oscSel][DATA_W-1:0];
      GRP_FREQ_HI:  oscByte = oscFreq[oscSel][FREQ_W-1:DATA_W];
      GRP_VOLUME:   oscByte = oscVolume[oscSel];
      GRP_SAMPLE:   oscByte = oscSample[oscSel];
      GRP_PTR_PAGE: oscByte = oscPtrPage[oscSel][DATA_W-1:0];
      GRP_CONTROL:  oscByte = oscControl[oscSel];
      GRP_PACKED:   oscByte = {1'b0, oscPtrPage[oscSel][PAGE_W-1],
                               oscTblSize[oscSel], oscRes[oscSel]};
      default:      oscByte = '0;
    endcase
  end

  always_comb begin
    unique case (strb.glb)
      GLB_STATUS: globalByte = (found ? winCode : statusReg) | STATUS_OR;
      GLB_COUNT:  globalByte = {1'b0, enCount - CNT_W'(1), 1'b0};
      GLB_ADC:    globalByte = adcValue;
      default:    globalByte = '0;
    endcase
  end

  assign nextData = strb.oscRead ? oscByte : globalByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData    <= '0;
      statusReg <= '0;
      irqOut    <= 1'b0;
    end else begin
      if (strb.load) rdData <= nextData;
      if (strb.popStatus && found) statusReg <= winCode | 8'h80;
      irqOut <= |(eligible & ~pendClear);
    end
  end

  AST_CLEAR_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pendClear)); // R4
  AST_CLEAR_NEEDS_POP: assert property (@(posedge clk) disable iff (!rstN)
    (|pendClear) |-> strb.popStatus); // R4
  AST_CLEAR_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    (pendClear & ~irqPend) == '0); // R4
  AST_STATUS_MARKERS: assert property (@(posedge clk) disable iff (!rstN)
    strb.popStatus |=> (rdData[0] && rdData[6])); // R5
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (|pendClear) |=> statusReg[7]); // R5
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (irqPend == '0) |=> !irqOut); // R6
endmodule

// File: rtl/snd_rd_decoder.sv
module snd_rd_decoder
  import snd_rd_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            rdEn,
  input  logic [ADDR_W-1:0]               rdAddr,
  input  logic [NUM_OSC-1:0][FREQ_W-1:0]  oscFreq,
  input  logic [NUM_OSC-1:0][DATA_W-1:0]  oscVolume,
  input  logic [NUM_OSC-1:0][DATA_W-1:0]  oscSample,
  input  logic [NUM_OSC-1:0][PAGE_W-1:0]  oscPtrPage,
  input  logic [NUM_OSC-1:0][DATA_W-1:0]  oscControl,
  input  logic [NUM_OSC-1:0][TBL_W-1:0]   oscTblSize,
  input  logic [NUM_OSC-1:0][RES_W-1:0]   oscRes,
  input  logic [NUM_OSC-1:0]              irqPend,
  input  logic [CNT_W-1:0]                enCount,
  input  logic [DATA_W-1:0]               adcValue,
  output logic [DATA_W-1:0]               rdData,
  output logic                            rdValid,
  output logic                            irqOut,
  output logic [NUM_OSC-1:0]              pendClear
);
  rdStrobe_t        strb;
  logic [IDX_W-1:0] oscSel;

  snd_rd_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .rdEn    (rdEn),
    .rdAddr  (rdAddr),
    .strb    (strb),
    .oscSel  (oscSel),
    .rdValid (rdValid)
  );

  snd_rd_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .oscSel     (oscSel),
    .oscFreq    (oscFreq),
    .oscVolume  (oscVolume),
    .oscSample  (oscSample),
    .oscPtrPage (oscPtrPage),
    .oscControl (oscControl),
    .oscTblSize (oscTblSize),
    .oscRes     (oscRes),
    .irqPend    (irqPend),
    .enCount    (enCount),
    .adcValue   (adcValue),
    .rdData     (rdData),
    .irqOut     (irqOut),
    .pendClear  (pendClear)
  );
endmodule

// File: tb/snd_rd_decoder_tb.sv
module snd_rd_decoder_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rdEn = 1'b0;
  logic [7:0] rdAddr = '0;
  logic [31:0][15:0] freq;
  logic [31:0][7:0]  vol;
  logic [31:0][7:0]  smp;
  logic [31:0][8:0]  page;
  logic [31:0][7:0]  ctl;
  logic [31:0][2:0]  tsz;
  logic [31:0][2:0]  res;
  logic [31:0] irqPendDrv = '0;
  logic [31:0] setNow = '0;
  logic [5:0]  enCnt = 6'd32;
  logic [7:0]  adc = 8'h5C;
  logic [7:0]  rdData;
  logic        rdValid;
  logic        irqOut;
  logic [31:0] pendClear;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  logic [7:0]  expData = '0;
  logic        expValid = 1'b0;
  logic        expIrq = 1'b0;
  logic [7:0]  statusModel = '0;
  logic [31:0] pendModel = '0;
  string       expTag = "R11";

  always #5 clk = ~clk;

  snd_rd_decoder u_dut (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdAddr(rdAddr),
    .oscFreq(freq), .oscVolume(vol), .oscSample(smp), .oscPtrPage(page),
    .oscControl(ctl), .oscTblSize(tsz), .oscRes(res), .irqPend(irqPendDrv),
    .enCount(enCnt), .adcValue(adc), .rdData(rdData), .rdValid(rdValid),
    .irqOut(irqOut), .pendClear(pendClear)
  );

  function automatic int lowestPending(logic [31:0] p, logic [5:0] cnt);
    for (int i = 0; i < 32; i++)
      if (p[i] && i < int'(cnt)) return i;
    return -1;
  endfunction

  function automatic logic [7:0] oscValue(logic [7:0] a);
    int v = int'(a[4:0]);
    case (a[7:5])
      3'd0: return freq[v][7:0];     // R1
      3'd1: return freq[v][15:8];
      3'd2: return vol[v];
      3'd3: return smp[v];
      3'd4: return page[v][7:0];
      3'd5: return ctl[v];
      default: return {1'b0, page[v][8], tsz[v], res[v]}; // R2
    endcase
  endfunction

  function automatic string tagFor(logic [7:0] a);
    if (a < 8'hC0) return "R1";
    if (a < 8'hE0) return "R2";
    if (a == 8'hE0) return "R5";
    if (a == 8'hE1) return "R7";
    if (a == 8'hE2) return "R8";
    return "R9";
  endfunction

  task automatic check(logic [31:0] act, logic [31:0] exp, string tag, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // reference model, advanced on every clock edge
  always @(posedge clk) begin
    int w;
    logic [31:0] clr;
    if (!rstN) begin
      expData = '0; expValid = 1'b0; expIrq = 1'b0;
      statusModel = '0; pendModel = '0;
      irqPendDrv <= '0;
    end else begin
      clr = '0;
      w = lowestPending(irqPendDrv, enCnt);
      expValid = rdEn;
      if (rdEn) begin
        expTag = tagFor(rdAddr);
        if (rdAddr < 8'hE0) expData = oscValue(rdAddr);
        else if (rdAddr == 8'hE0) begin
          if (w >= 0) begin
            clr[w] = 1'b1;
            expData = 8'(w << 1) | 8'h41;
            statusModel = 8'(w << 1) | 8'h80;
          end else expData = statusModel | 8'h41;
        end
        else if (rdAddr == 8'hE1) expData = 8'(int'(enCnt) - 1) << 1;
        else if (rdAddr == 8'hE2) expData = adc;
        else expData = 8'h00;
      end
      expIrq = 1'b0;
      for (int i = 0; i < 32; i++)
        if (irqPendDrv[i] && !clr[i] && i < int'(enCnt)) expIrq = 1'b1;
      pendModel = (irqPendDrv & ~clr) | setNow;
      irqPendDrv <= pendModel;
    end
  end

  // compare mid-cycle on every clock
  always @(negedge clk) begin
    logic [31:0] ec;
    int w;
    if (rstN && !done) begin
      check(32'(rdValid), 32'(expValid), "R3", "rdValid");
      if (expValid) check(32'(rdData), 32'(expData), expTag, "rdData");
      check(32'(irqOut), 32'(expIrq), "R6", "irqOut");
      ec = '0;
      w = lowestPending(irqPendDrv, enCnt);
      if (rdEn && rdAddr == 8'hE0 && w >= 0) ec[w] = 1'b1;
      check(pendClear, ec, "R4", "pendClear");
    end
  end

  task automatic doRead(logic [7:0] a, logic [31:0] sets = '0);
    @(posedge clk); #1;
    rdEn = 1'b1; rdAddr = a; setNow = sets;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      rdEn = 1'b0; setNow = '0;
    end
  endtask

  task automatic inject(logic [31:0] m);
    @(posedge clk); #1;
    rdEn = 1'b0; setNow = m;
    idle(2);
  endtask

  // read the status register and check the reported byte one cycle later
  task automatic popExpect(logic [7:0] exp, string tag);
    doRead(8'hE0);
    idle(1);
    @(negedge clk);
    check(32'(rdData), 32'(exp), tag, "status read");
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin
      freq[i] = 16'hA000 ^ 16'(i * 16'h0713);
      vol[i]  = 8'(8'h10 + i * 3);
      smp[i]  = 8'(8'hFF - i * 5);
      page[i] = 9'(i * 9'h02B);
      ctl[i]  = 8'(i * 7 + 1);
      tsz[i]  = 3'(i % 8);
      res[i]  = 3'((i * 3) % 8);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(32'(rdData), 0, "R11", "reset rdData");
    check(32'(rdValid), 0, "R11", "reset rdValid");
    check(32'(irqOut), 0, "R11", "reset irqOut");
    @(posedge clk); #1; rstN = 1'b1;
    idle(2);
    // R1 R2: every per-voice offset
    for (int a = 0; a < 224; a++) doRead(8'(a));
    idle(2);
    // R7 R8 R9 globals
    doRead(8'hE1); doRead(8'hE2);
    for (int a = 227; a < 256; a++) doRead(8'(a));
    idle(1);
    // R5: empty status read returns reset status | 0x41
    popExpect(8'h41, "R5");
    // R4 R5 R6: priority order, back-to-back pops
    inject(32'h0002_0028);           // voices 3, 5, 17
    doRead(8'hE0); doRead(8'hE0); doRead(8'hE0); doRead(8'hE0);
    idle(2);
    @(negedge clk);
    check(32'(rdData), 32'hE3, "R5", "sticky status after drain");
    check(32'(irqOut), 0, "R6", "irq low after drain");
    // R4: disabled voice ignored
    enCnt = 6'd8;
    inject(32'h0000_1004);           // voices 2 and 12
    popExpect(8'h45, "R4");
    popExpect(8'hC5, "R4");
    @(negedge clk);
    check(32'(irqOut), 0, "R6", "irq ignores disabled voice");
    @(posedge clk); #1; enCnt = 6'd32;
    idle(2);
    @(negedge clk);
    check(32'(irqOut), 1, "R6", "irq rises when voice enabled");
    popExpect(8'h59, "R4");
    // R10: re-set during the read that clears it
    inject(32'h0000_0210);           // voices 4 and 9
    doRead(8'hE0, 32'h0010_0010);    // clears 4, sets 4 and 20
    idle(2);
    popExpect(8'h49, "R10");
    popExpect(8'h53, "R10");
    popExpect(8'h69, "R10");
    // R7 with other counts
    @(posedge clk); #1; enCnt = 6'd1;
    doRead(8'hE1); idle(1);
    @(negedge clk); check(32'(rdData), 0, "R7", "count one");
    @(posedge clk); #1; enCnt = 6'd17;
    doRead(8'hE1); idle(1);
    @(negedge clk); check(32'(rdData), 32, "R7", "count seventeen");
    @(posedge clk); #1; enCnt = 6'd32; adc = 8'hA7;
    doRead(8'hE2); idle(1);
    @(negedge clk); check(32'(rdData), 32'hA7, "R8", "adc byte");
    // R4: extremes 0 and 31
    inject(32'h8000_0001);
    popExpect(8'h41, "R4");
    popExpect(8'h7F, "R4");
    idle(3);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule